// File: doc/BRIEF.md
# Sixty-Four Source Interrupt Controller

This block gathers up to 63 active-low interrupt sources, numbered 1 to 63, into one request line for a processor. Number 0 is reserved and means "nothing pending". Each source has a pending bit and an enable bit in one of two 32-bit register words, high and low. The word and the bit a source uses come from a fixed table, not from the source number. Software enables sources in the mask words and clears captured edges by writing ones to the pending words. It then reads a vector word that gives the lowest-numbered source that is both pending and enabled.

Most sources are internal and always level-sensitive, active-low. Sources 19 to 25 are external. Each can be set to level-low or falling-edge with a bit in the edge-control word. Sources 48 to 63 are port sources. Each can be set to capture both edges or only the falling edge. The raw inputs must already be synchronous to `clk`.

Top module: `sixty_four_irq_ctrl`

## Requirements
- R1: After reset both mask words and the edge-control word read 0, every edge capture is empty, `irq_o` is low, and the vector reads 0 while all inputs are high.
- R2: Sources 1 to 15 use the high word at bit 16-n, and sources 32 to 47 use the high word at bit 63-n.
- R3: Sources 16 to 18 use the low word at bit 18-n, sources 19 to 30 at bit 33-n, source 31 at bit 0 (shared with source 18), and sources 48 to 63 at bit n-32.
- R4: A level-sensitive source's pending bit reads 1 exactly while its input is low, and writing 1 to that bit does not clear it while the input is still low.
- R5: External source n (19 to 25) has an edge-select bit at position 33-n of the edge-control word. A value of 1 latches a falling edge until it is cleared; a value of 0 gives level-low behaviour.
- R6: Port source n (48 to 63) has an edge-select bit at position n-32. A value of 0 latches both falling and rising edges; a value of 1 latches only falling edges, so a rising edge leaves the pending bit at 0.
- R7: Writing 1 to a pending bit clears a latched edge. Writing 0 leaves it set. An edge that arrives in the same cycle as the clear keeps the bit set.
- R8: A mask bit of 1 enables its source. `irq_o` is high exactly when some pending bit has its mask bit set.
- R9: The vector word holds the lowest enabled pending source number in bits 31:26, with bits 25:0 zero. It reads 0 when no source qualifies, and a masked source never appears in it.
- R10: Only the 23 edge-select bits (8 to 14 and 16 to 31) of the edge-control word can be written. All other bits read 0.
- R11: The word addresses are: 0 vector (read-only; writes to it are ignored), 1 mask high, 2 mask low, 3 pending high, 4 pending low, 5 edge control. `bus_rdata` is 0 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Write strobe, committed on the rising clock edge |
| bus_rd | input | 1 | Read strobe; read data is combinational |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| src_n_i | input | 64 | Raw active-low sources; bit n is source n, bit 0 unused |
| irq_o | output | 1 | Interrupt request |

## Verification
Some properties are checked by assertions on every cycle. A detected edge always appears as a captured pending bit on the next cycle. A write-one with no new edge always empties the capture. `irq_o` always agrees with a nonzero vector. The reported vector is always an active source with no lower active source. The low 26 bits of the vector read are always zero. Other behaviour can only be shown by the bench's scenarios: the non-arithmetic bit mapping of every source, the different meaning of edge-select in the external and port groups, and the edge-control bits that cannot be written.

// File: rtl/irq_map_pkg.sv
package irq_map_pkg;
  localparam int NSRC   = 64;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 3;
  localparam int VEC_W  = $clog2(NSRC);

  localparam logic [ADDR_W-1:0] A_VEC    = 3'd0;
  localparam logic [ADDR_W-1:0] A_MASK_H = 3'd1;
  localparam logic [ADDR_W-1:0] A_MASK_L = 3'd2;
  localparam logic [ADDR_W-1:0] A_PEND_H = 3'd3;
  localparam logic [ADDR_W-1:0] A_PEND_L = 3'd4;
  localparam logic [ADDR_W-1:0] A_EDGE   = 3'd5;

  // source lives in the high word?
  function automatic logic in_high(input int n);
    return (n < 16) || (n >= 32 && n < 48);
  endfunction

  // bit position of a source inside its word
  function automatic logic [4:0] bit_of(input int n);
    int b;
    if (n < 16)      b = (n == 0) ? 0 : 16 - n;
    else if (n < 19) b = 18 - n;
    else if (n < 31) b = 33 - n;
    else if (n < 32) b = 0;
    else if (n < 48) b = 63 - n;
    else             b = n - 32;
    return 5'(b);
  endfunction

  function automatic logic is_ext(input int n);
    return n >= 19 && n <= 25;
  endfunction

  function automatic logic is_port(input int n);
    return n >= 48 && n <= 63;
  endfunction

  // edge-select position for external / port sources
  function automatic logic [4:0] esel_pos(input int n);
    return is_ext(n) ? 5'(33 - n) : 5'(n - 32);
  endfunction

  function automatic logic [DATA_W-1:0] edge_writable();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int n = 0; n < NSRC; n++)
      if (is_ext(n) || is_port(n)) m[esel_pos(n)] = 1'b1;
    return m;
  endfunction

  // which sources feed a given bit of a given word
  function automatic logic [NSRC-1:0] feeders(input logic hi, input int b);
    logic [NSRC-1:0] m;
    m = '0;
    for (int n = 1; n < NSRC; n++)
      if (in_high(n) == hi && int'(bit_of(n)) == b) m[n] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/irq_sense.sv
module irq_sense
  import irq_map_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_n_i,
  input  logic [NSRC-1:0] edge_en_i,
  input  logic [NSRC-1:0] both_en_i,
  input  logic [NSRC-1:0] clr_i,
  output logic [NSRC-1:0] req_o,
  output logic [NSRC-1:0] evt_o
);
  logic [NSRC-1:0] raw_q, cap_q, fall_w, rise_w;

  assign fall_w = raw_q & ~src_n_i;
  assign rise_w = ~raw_q & src_n_i;
  assign evt_o  = edge_en_i & (fall_w | (both_en_i & rise_w));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '1;
      cap_q <= '0;
    end else begin
      raw_q <= src_n_i;
      cap_q <= edge_en_i & ((cap_q & ~clr_i) | evt_o);
    end
  end

  assign req_o[0] = 1'b0;

  for (genvar n = 1; n < NSRC; n++) begin : g_src
    assign req_o[n] = edge_en_i[n] ? cap_q[n] : ~src_n_i[n];

    assert_edge_captured_R5: assert property (@(posedge clk) disable iff (!rst_n)
      evt_o[n] |=> cap_q[n]);
    assert_w1c_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i[n] && !evt_o[n]) |=> !cap_q[n]);
  end
endmodule

// File: rtl/irq_vec_enc.sv
module irq_vec_enc
  import irq_map_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  act_i,
  output logic [VEC_W-1:0] vec_o
);
  always_comb begin
    vec_o = '0;
    for (int i = NSRC - 1; i >= 1; i--)
      if (act_i[i]) vec_o = VEC_W'(i);
  end

  logic [NSRC-1:0] below_w;
  assign below_w = act_i & ((64'd1 << vec_o) - 64'd1);

  assert_vec_is_active_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_o != '0) |-> act_i[vec_o]);
  assert_vec_is_lowest_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_o != '0) |-> (below_w == '0));
endmodule

// File: rtl/sixty_four_irq_ctrl.sv
module sixty_four_irq_ctrl
  import irq_map_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [63:0]       src_n_i,
  output logic              irq_o
);
  localparam logic [DATA_W-1:0] EDGE_WR = edge_writable();

  logic [DATA_W-1:0] mask_h_q, mask_l_q, edge_q;
  logic [DATA_W-1:0] pend_h, pend_l;
  logic [NSRC-1:0]   edge_en, both_en, clr_src, req, evt, act;
  logic [VEC_W-1:0]  vec;
  logic              wr_pend_h, wr_pend_l;

  assign wr_pend_h = bus_wr && bus_addr == A_PEND_H;
  assign wr_pend_l = bus_wr && bus_addr == A_PEND_L;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_h_q <= '0;
      mask_l_q <= '0;
      edge_q   <= '0;
    end else if (bus_wr) begin
      case (bus_addr)
        A_MASK_H: mask_h_q <= bus_wdata;
        A_MASK_L: mask_l_q <= bus_wdata;
        A_EDGE:   edge_q   <= bus_wdata & EDGE_WR;
        default:  ;
      endcase
    end
  end

  // per-source sense selection and clear decode
  assign edge_en[0] = 1'b0;
  assign both_en[0] = 1'b0;
  assign clr_src[0] = 1'b0;
  assign act[0]     = 1'b0;
  for (genvar n = 1; n < NSRC; n++) begin : g_cfg
    localparam logic [4:0] B = bit_of(n);
    localparam logic       H = in_high(n);
    if (is_ext(n)) begin : g_ext
      assign edge_en[n] = edge_q[esel_pos(n)];
      assign both_en[n] = 1'b0;
    end else if (is_port(n)) begin : g_port
      assign edge_en[n] = 1'b1;
      assign both_en[n] = ~edge_q[esel_pos(n)];
    end else begin : g_int
      assign edge_en[n] = 1'b0;
      assign both_en[n] = 1'b0;
    end
    assign clr_src[n] = (H ? wr_pend_h : wr_pend_l) && bus_wdata[B];
    assign act[n]     = H ? (pend_h[B] & mask_h_q[B]) : (pend_l[B] & mask_l_q[B]);
  end

  // fold source requests onto register bits
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    localparam logic [NSRC-1:0] FH = feeders(1'b1, b);
    localparam logic [NSRC-1:0] FL = feeders(1'b0, b);
    assign pend_h[b] = |(req & FH);
    assign pend_l[b] = |(req & FL);
  end

  irq_sense u_sense (
    .clk(clk), .rst_n(rst_n), .src_n_i(src_n_i),
    .edge_en_i(edge_en), .both_en_i(both_en), .clr_i(clr_src),
    .req_o(req), .evt_o(evt)
  );

  irq_vec_enc u_enc (.clk(clk), .rst_n(rst_n), .act_i(act), .vec_o(vec));

  assign irq_o = |(pend_h & mask_h_q) | |(pend_l & mask_l_q);

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_VEC:    bus_rdata = {vec, {(DATA_W-VEC_W){1'b0}}};
        A_MASK_H: bus_rdata = mask_h_q;
        A_MASK_L: bus_rdata = mask_l_q;
        A_PEND_H: bus_rdata = pend_h;
        A_PEND_L: bus_rdata = pend_l;
        A_EDGE:   bus_rdata = edge_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  assert_irq_matches_vec_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (vec != '0));
  assert_masked_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_h_q == '0 && mask_l_q == '0) |-> !irq_o);
  assert_vec_low_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_VEC) |-> (bus_rdata[25:0] == '0));
  assert_edge_unwritable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == A_EDGE) |-> ((bus_rdata & ~EDGE_WR) == '0));
endmodule

// File: tb/tb_sixty_four_irq_ctrl.sv
module tb_sixty_four_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] src_n_i = '1;
  logic        irq_o;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  sixty_four_irq_ctrl dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk); #1;
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    #0.5 d = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic drive(int n, logic v);
    @(negedge clk);
    src_n_i[n] = v;
    @(posedge clk); #1;
  endtask

  // independent restatement of the mapping table
  function automatic void loc(int n, output logic hi, output int b);
    case (1'b1)
      (n >= 1 && n <= 15):  begin hi = 1; b = 16 - n; end
      (n >= 16 && n <= 18): begin hi = 0; b = 18 - n; end
      (n >= 19 && n <= 30): begin hi = 0; b = 33 - n; end
      (n == 31):            begin hi = 0; b = 0;      end
      (n >= 32 && n <= 47): begin hi = 1; b = 63 - n; end
      default:              begin hi = 0; b = n - 32; end
    endcase
  endfunction

  task automatic t_reset;
    logic [31:0] d;
    rd(3'd1, d); check("R1 mask high", d, 0);
    rd(3'd2, d); check("R1 mask low", d, 0);
    rd(3'd5, d); check("R1 edge ctl", d, 0);
    rd(3'd0, d); check("R1 vector", d, 0);
    rd(3'd3, d); check("R1 pend high", d, 0);
    rd(3'd4, d); check("R1 pend low", d, 0);
    check("R1 irq", {31'd0, irq_o}, 0);
  endtask

  task automatic t_level_map;
    logic [31:0] dh, dl, eh, el;
    logic hi; int b;
    for (int n = 1; n < 48; n++) begin
      loc(n, hi, b);
      drive(n, 1'b0);
      eh = hi ? (32'd1 << b) : 0;
      el = hi ? 0 : (32'd1 << b);
      rd(3'd3, dh); rd(3'd4, dl);
      check(hi ? "R2 high map" : "R3 low map", dh, eh);
      check(hi ? "R2 high map other word" : "R3 low map", dl, el);
      drive(n, 1'b1);
      rd(3'd3, dh); rd(3'd4, dl);
      check("R4 level released", dh | dl, 0);
    end
    // R4: write-one ignored while level is active
    drive(3, 1'b0);
    wr(3'd3, 32'd1 << 13);
    rd(3'd3, dh); check("R4 w1c ignored on level", dh, 32'd1 << 13);
    drive(3, 1'b1);
  endtask

  task automatic t_mask_vector;
    logic [31:0] d;
    rd(3'd0, d);
    wr(3'd1, (32'd1 << 11) | (32'd1 << 23));  // src5, src40
    wr(3'd2, 32'd1 << 13);                     // src20
    drive(40, 1'b0);
    rd(3'd0, d); check("R9 vector 40", d, 32'd40 << 26);
    check("R8 irq on", {31'd0, irq_o}, 1);
    drive(20, 1'b0);
    rd(3'd0, d); check("R9 vector 20", d, 32'd20 << 26);
    drive(5, 1'b0);
    rd(3'd0, d); check("R9 vector 5", d, 32'd5 << 26);
    drive(3, 1'b0);
    rd(3'd0, d); check("R9 masked 3 skipped", d, 32'd5 << 26);
    wr(3'd0, 32'hFFFF_FFFF);
    rd(3'd0, d); check("R11 vector write ignored", d, 32'd5 << 26);
    drive(5, 1'b1); drive(20, 1'b1); drive(40, 1'b1);
    rd(3'd0, d); check("R9 vector none", d, 0);
    check("R8 irq masked-only", {31'd0, irq_o}, 0);
    drive(3, 1'b1);
    wr(3'd1, 0); wr(3'd2, 0);
  endtask

  task automatic t_ext_edge;
    logic [31:0] d;
    wr(3'd5, 32'd1 << 12);  // src21 falling
    rd(3'd5, d); check("R5 edge readback", d, 32'd1 << 12);
    drive(21, 1'b0); drive(21, 1'b1);
    rd(3'd4, d); check("R5 falling latched", d, 32'd1 << 12);
    wr(3'd4, 32'd0);
    rd(3'd4, d); check("R7 write zero keeps", d, 32'd1 << 12);
    wr(3'd4, 32'd1 << 12);
    rd(3'd4, d); check("R7 write one clears", d, 0);
    wr(3'd5, 0);
    drive(21, 1'b0);
    rd(3'd4, d); check("R5 level mode active", d, 32'd1 << 12);
    drive(21, 1'b1);
    rd(3'd4, d); check("R5 level mode released", d, 0);
  endtask

  task automatic t_port_edge;
    logic [31:0] d;
    drive(50, 1'b0);
    rd(3'd4, d); check("R6 both: fall", d, 32'd1 << 18);
    wr(3'd4, 32'd1 << 18);
    rd(3'd4, d); check("R7 port clear", d, 0);
    drive(50, 1'b1);
    rd(3'd4, d); check("R6 both: rise", d, 32'd1 << 18);
    wr(3'd4, 32'hFFFF_FFFF);
    wr(3'd5, 32'd1 << 18);
    drive(50, 1'b0);
    rd(3'd4, d); check("R6 fall-only: fall", d, 32'd1 << 18);
    wr(3'd4, 32'd1 << 18);
    drive(50, 1'b1);
    rd(3'd4, d); check("R6 fall-only: rise ignored", d, 0);
    wr(3'd5, 0);
  endtask

  task automatic t_edge_bits;
    logic [31:0] d;
    wr(3'd5, 32'hFFFF_FFFF);
    rd(3'd5, d); check("R10 writable bits", d, 32'hFFFF_7F00);
    wr(3'd5, 0);
    rd(3'd5, d); check("R10 cleared", d, 0);
  endtask

  initial begin
    fork
      begin
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        t_reset();
        t_level_map();
        t_mask_vector();
        t_ext_edge();
        t_port_edge();
        t_edge_bits();
      end
      begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule